// File: doc/BRIEF.md
# Interrupt return control unit

This block carries out the return-from-interrupt instruction for a small pipelined 32-bit core. It recognises the instruction in the execute stage and passes the register select field to the register file. It then forms the jump address from the returned register value plus the sign-extended 16-bit offset. The jump is delayed by exactly one slot. The instruction after the return always completes first, and during that slot interrupts stay masked and both interrupt and break requests are held back.

When the slot instruction has completed, the unit raises the branch and the status write together for one cycle. The status write sets interrupt enable and copies the saved user-mode and virtual-mode bits back into the live ones. If memory protection is configured and the core is in user mode, the unit does not branch. It signals a privileged-instruction exception with its cause code instead.

A 2-bit acknowledge output follows the return in low-latency interrupt mode. The unit also flags any delay-slot instruction that may not legally sit there.

Top module: `irq_return_ctrl`

## Requirements
- R1: The return is recognised when `instr[31:26]` is 101101 and `instr[25:21]` is 10001, `instr_valid` is 1, `stall` is 0 and no return is in progress. `ra_sel` always shows `instr[20:16]`. Any other value of `instr[25:21]` is not a return.
- R2: `branch_target` equals `reg_a` (sampled when the return is accepted) plus `instr[15:0]` sign-extended to 32 bits, with the sum taken modulo 2^32. `branch_valid` is a one-cycle pulse.
- R3: The branch happens only after one delay-slot instruction has completed (`instr_valid`=1 and `stall`=0 in the slot). `branch_valid` rises in the cycle after that completion. Bubbles and stalled cycles in the slot do not end it.
- R4: `irq_take` is `irq_req` and `st_ie_in`, and `brk_take` is `brk_req`, both forced to 0 from the cycle the return is presented until the cycle in which `branch_valid` is shown. Outside that window they follow their requests.
- R5: If `mem_prot_en`=1 and `st_um_in`=1 when a return is presented, `exc_valid` pulses for one cycle in the next cycle with `exc_code`=5'b00111. No branch or status write follows, and `irq_ack` stays 2'b00.
- R6: In the cycle `branch_valid` is 1, `st_we`=1 and `st_ie`=1. `st_um` and `st_vm` carry the `st_ums_in` and `st_vms_in` values sampled when the return was accepted.
- R7: `irq_ack` rests at 2'b00. It shows 2'b10 from the cycle after acceptance, 2'b11 in the cycle after the status write, and 2'b00 again one cycle later.
- R8: `irq_ack` does not change in the cycle following one with `stall`=1. A status write made while stalled still produces 2'b11 once the stall ends.
- R9: `illegal_slot` is 1 while a valid slot instruction has `instr[31:26]` equal to 101100, 100110, 101110, 100111, 101111 or 101101, and is 0 otherwise.
- R10: After reset all outputs except `ra_sel` are 0, and `irq_ack` is 2'b00.
- R11: With `mem_prot_en`=0 a return executes normally even when `st_um_in`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Pipeline hold |
| mem_prot_en | input | 1 | Memory protection configured |
| instr_valid | input | 1 | Execute-stage instruction present |
| instr | input | 32 | Execute-stage instruction word |
| reg_a | input | XLEN | Value of the selected register |
| ra_sel | output | 5 | Register select to the register file |
| st_ie_in | input | 1 | Current interrupt enable |
| st_um_in | input | 1 | Current user mode |
| st_ums_in | input | 1 | Saved user mode |
| st_vms_in | input | 1 | Saved virtual mode |
| irq_req | input | 1 | Interrupt request |
| brk_req | input | 1 | External break request |
| irq_take | output | 1 | Interrupt accepted this cycle |
| brk_take | output | 1 | Break accepted this cycle |
| branch_valid | output | 1 | Redirect fetch to target |
| branch_target | output | XLEN | Jump address |
| st_we | output | 1 | Status write strobe |
| st_ie | output | 1 | New interrupt enable |
| st_um | output | 1 | New user mode |
| st_vm | output | 1 | New virtual mode |
| exc_valid | output | 1 | Privileged-instruction exception |
| exc_code | output | 5 | Exception cause |
| illegal_slot | output | 1 | Forbidden delay-slot instruction |
| irq_ack | output | 2 | Interrupt acknowledge code |

## Verification
The bench builds the block with its defaults: XLEN of 32 and LOWLAT_ACK set to 1. With these values the acknowledge sequence, including its hold under stall, can be observed at the port. Memory protection is a port, so both its settings are driven within one build. That makes both the exception path and the user-mode return without protection reachable.

// File: rtl/irq_ret_pkg.sv
`timescale 1ns/1ps
package irq_ret_pkg;
  localparam int INSTR_W = 32;
  localparam int IMM_W   = 16;
  localparam int RSEL_W  = 5;
  localparam int EC_W    = 5;

  localparam logic [5:0] OPC_RET = 6'b101101;
  localparam logic [4:0] SUB_RET = 5'b10001;
  localparam logic [5:0] OPC_IMM = 6'b101100;
  localparam logic [5:0] OPC_BR  = 6'b100110;
  localparam logic [5:0] OPC_BRI = 6'b101110;
  localparam logic [5:0] OPC_BC  = 6'b100111;
  localparam logic [5:0] OPC_BCI = 6'b101111;

  localparam logic [EC_W-1:0] EC_PRIV = 5'b00111;

  localparam logic [1:0] ACK_IDLE = 2'b00;
  localparam logic [1:0] ACK_RET  = 2'b10;
  localparam logic [1:0] ACK_ENA  = 2'b11;

  typedef enum logic [1:0] {SQ_IDLE, SQ_SLOT, SQ_DONE} sq_state_e;
endpackage

// File: rtl/irq_ret_rst_sync.sv
`timescale 1ns/1ps
module irq_ret_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic q0, q1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q0 <= 1'b0;
      q1 <= 1'b0;
    end else begin
      q0 <= 1'b1;
      q1 <= q0;
    end
  end
  assign rst_sync_n = q1;
endmodule

// File: rtl/irq_ret_decode.sv
`timescale 1ns/1ps
module irq_ret_decode
  import irq_ret_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic [XLEN-1:0]    reg_a,
  output logic               is_ret,
  output logic               is_forbidden,
  output logic [RSEL_W-1:0]  ra_sel,
  output logic [XLEN-1:0]    target
);
  localparam int EXT_W = XLEN - IMM_W;

  logic [5:0]       opc;
  logic [4:0]       sub;
  logic [IMM_W-1:0] imm;
  logic [XLEN-1:0]  imm_ext;

  assign opc    = instr[31:26];
  assign sub    = instr[25:21];
  assign ra_sel = instr[20:16];
  assign imm    = instr[IMM_W-1:0];

  assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign target  = reg_a + imm_ext;

  assign is_ret = (opc == OPC_RET) && (sub == SUB_RET);

  always_comb begin
    unique case (opc)
      OPC_IMM, OPC_BR, OPC_BRI, OPC_BC, OPC_BCI, OPC_RET: is_forbidden = 1'b1;
      default:                                           is_forbidden = 1'b0;
    endcase
  end
endmodule

// File: rtl/irq_ret_seq.sv
`timescale 1ns/1ps
module irq_ret_seq
  import irq_ret_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall,
  input  logic            instr_valid,
  input  logic            is_ret,
  input  logic            is_forbidden,
  input  logic [XLEN-1:0] target_in,
  input  logic            mem_prot_en,
  input  logic            um_in,
  input  logic            ums_in,
  input  logic            vms_in,
  output logic            ret_accept,
  output logic            hold,
  output logic            in_slot,
  output logic            in_done,
  output logic [XLEN-1:0] tgt_out,
  output logic            ums_out,
  output logic            vms_out,
  output logic            exc_out,
  output logic            illegal_out
);
  sq_state_e       state_q, state_d;
  logic [XLEN-1:0] tgt_q;
  logic            ums_q, vms_q, exc_q;
  logic            idle, ret_hit, priv_fail, slot_done;

  assign idle      = (state_q == SQ_IDLE);
  assign ret_hit   = idle && instr_valid && is_ret && !stall;
  assign priv_fail = ret_hit && mem_prot_en && um_in;
  assign ret_accept = ret_hit && !priv_fail;
  assign slot_done = (state_q == SQ_SLOT) && instr_valid && !stall;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE: if (ret_accept) state_d = SQ_SLOT;
      SQ_SLOT: if (slot_done)  state_d = SQ_DONE;
      SQ_DONE:                 state_d = SQ_IDLE;
      default:                 state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      exc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      exc_q   <= priv_fail;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
      ums_q <= 1'b0;
      vms_q <= 1'b0;
    end else if (ret_accept) begin
      tgt_q <= target_in;
      ums_q <= ums_in;
      vms_q <= vms_in;
    end
  end

  assign in_slot     = (state_q == SQ_SLOT);
  assign in_done     = (state_q == SQ_DONE);
  assign hold        = !idle || (instr_valid && is_ret);
  assign tgt_out     = tgt_q;
  assign ums_out     = ums_q;
  assign vms_out     = vms_q;
  assign exc_out     = exc_q;
  assign illegal_out = in_slot && instr_valid && is_forbidden;
endmodule

// File: rtl/irq_ret_ack.sv
`timescale 1ns/1ps
module irq_ret_ack
  import irq_ret_pkg::*;
#(
  parameter bit LOWLAT_ACK = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stall,
  input  logic       ret_accept,
  input  logic       in_done,
  output logic [1:0] ack
);
  generate
    if (LOWLAT_ACK) begin : g_ack
      logic [1:0] ack_q, ack_d;
      logic       pend_q, pend_d;

      always_comb begin
        ack_d  = ack_q;
        pend_d = pend_q;
        if (stall) begin
          if (in_done) pend_d = 1'b1;
        end else if (in_done || pend_q) begin
          ack_d  = ACK_ENA;
          pend_d = 1'b0;
        end else if (ret_accept) begin
          ack_d = ACK_RET;
        end else if (ack_q == ACK_ENA) begin
          ack_d = ACK_IDLE;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ack_q  <= ACK_IDLE;
          pend_q <= 1'b0;
        end else begin
          ack_q  <= ack_d;
          pend_q <= pend_d;
        end
      end
      assign ack = ack_q;
    end else begin : g_noack
      assign ack = ACK_IDLE;
    end
  endgenerate
endmodule

// File: rtl/irq_return_ctrl.sv
`timescale 1ns/1ps
module irq_return_ctrl
  import irq_ret_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter bit LOWLAT_ACK = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stall,
  input  logic                mem_prot_en,
  input  logic                instr_valid,
  input  logic [INSTR_W-1:0]  instr,
  input  logic [XLEN-1:0]     reg_a,
  output logic [RSEL_W-1:0]   ra_sel,
  input  logic                st_ie_in,
  input  logic                st_um_in,
  input  logic                st_ums_in,
  input  logic                st_vms_in,
  input  logic                irq_req,
  input  logic                brk_req,
  output logic                irq_take,
  output logic                brk_take,
  output logic                branch_valid,
  output logic [XLEN-1:0]     branch_target,
  output logic                st_we,
  output logic                st_ie,
  output logic                st_um,
  output logic                st_vm,
  output logic                exc_valid,
  output logic [EC_W-1:0]     exc_code,
  output logic                illegal_slot,
  output logic [1:0]          irq_ack
);
  logic            rst_sync_n;
  logic            is_ret, is_forbidden;
  logic [XLEN-1:0] target;
  logic            ret_accept, hold, in_slot, in_done;
  logic            ums_s, vms_s, exc_s;

  irq_ret_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  irq_ret_decode #(.XLEN(XLEN)) u_dec (
    .instr(instr), .reg_a(reg_a), .is_ret(is_ret),
    .is_forbidden(is_forbidden), .ra_sel(ra_sel), .target(target)
  );

  irq_ret_seq #(.XLEN(XLEN)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .stall(stall), .instr_valid(instr_valid),
    .is_ret(is_ret), .is_forbidden(is_forbidden), .target_in(target),
    .mem_prot_en(mem_prot_en), .um_in(st_um_in), .ums_in(st_ums_in),
    .vms_in(st_vms_in), .ret_accept(ret_accept), .hold(hold),
    .in_slot(in_slot), .in_done(in_done), .tgt_out(branch_target),
    .ums_out(ums_s), .vms_out(vms_s), .exc_out(exc_s),
    .illegal_out(illegal_slot)
  );

  irq_ret_ack #(.LOWLAT_ACK(LOWLAT_ACK)) u_ack (
    .clk(clk), .rst_n(rst_sync_n), .stall(stall),
    .ret_accept(ret_accept), .in_done(in_done), .ack(irq_ack)
  );

  assign branch_valid = in_done;
  assign st_we        = in_done;
  assign st_ie        = in_done;
  assign st_um        = in_done && ums_s;
  assign st_vm        = in_done && vms_s;
  assign exc_valid    = exc_s;
  assign exc_code     = exc_s ? EC_PRIV : '0;
  assign irq_take     = irq_req && st_ie_in && !hold;
  assign brk_take     = brk_req && !hold;
endmodule

// File: rtl/irq_ret_chk.sv
`timescale 1ns/1ps
module irq_ret_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stall,
  input logic       in_slot,
  input logic       irq_take,
  input logic       brk_take,
  input logic       exc_valid,
  input logic [4:0] exc_code,
  input logic       branch_valid,
  input logic       st_we,
  input logic [1:0] irq_ack
);
  AST_SLOT_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
    in_slot |-> (!irq_take && !brk_take)); // R4
  AST_EXC_NO_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (!branch_valid && !st_we && exc_code == 5'b00111)); // R5
  AST_EXC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> !exc_valid); // R5
  AST_BRANCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    branch_valid |=> !branch_valid); // R2
  AST_ACK_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(irq_ack)); // R8
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack == 2'b11 && !stall) |=> (irq_ack != 2'b11)); // R7
  AST_ACK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack == 2'b11) |-> ($past(irq_ack) == 2'b10 || $past(irq_ack) == 2'b11)); // R7
endmodule

bind irq_return_ctrl irq_ret_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .stall(stall), .in_slot(in_slot),
  .irq_take(irq_take), .brk_take(brk_take), .exc_valid(exc_valid),
  .exc_code(exc_code), .branch_valid(branch_valid), .st_we(st_we),
  .irq_ack(irq_ack)
);

// File: tb/test_irq_return_ctrl.sv
`timescale 1ns/1ps
module test_irq_return_ctrl;
  logic        clk = 1'b0;
  logic        rst_n, stall, mem_prot_en, instr_valid;
  logic [31:0] instr, reg_a, branch_target;
  logic [4:0]  ra_sel, exc_code;
  logic        st_ie_in, st_um_in, st_ums_in, st_vms_in, irq_req, brk_req;
  logic        irq_take, brk_take, branch_valid, st_we, st_ie, st_um, st_vm;
  logic        exc_valid, illegal_slot;
  logic [1:0]  irq_ack;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  irq_return_ctrl i_irq_return_ctrl (
    .clk(clk), .rst_n(rst_n), .stall(stall), .mem_prot_en(mem_prot_en),
    .instr_valid(instr_valid), .instr(instr), .reg_a(reg_a), .ra_sel(ra_sel),
    .st_ie_in(st_ie_in), .st_um_in(st_um_in), .st_ums_in(st_ums_in),
    .st_vms_in(st_vms_in), .irq_req(irq_req), .brk_req(brk_req),
    .irq_take(irq_take), .brk_take(brk_take), .branch_valid(branch_valid),
    .branch_target(branch_target), .st_we(st_we), .st_ie(st_ie),
    .st_um(st_um), .st_vm(st_vm), .exc_valid(exc_valid), .exc_code(exc_code),
    .illegal_slot(illegal_slot), .irq_ack(irq_ack)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ret_word(input logic [4:0] ra, input logic [15:0] imm);
    return {6'b101101, 5'b10001, ra, imm};
  endfunction

  localparam logic [31:0] ADD_WORD = 32'h0000_0000;

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    stall = 0; instr_valid = 0; instr = ADD_WORD; reg_a = 0;
    irq_req = 0; brk_req = 0; st_ie_in = 0; st_um_in = 0;
    st_ums_in = 0; st_vms_in = 0; mem_prot_en = 0;
  endtask

  task automatic t_reset();
    idle_inputs();
    rst_n = 0;
    repeat (3) nxt();
    rst_n = 1;
    repeat (3) nxt();
    check("R10 ack", {30'b0, irq_ack}, 0);
    check("R10 pulses", {26'b0, branch_valid, st_we, exc_valid, illegal_slot, st_um, st_vm}, 0);
    check("R10 target", branch_target, 0);
  endtask

  task automatic t_basic();
    instr = ret_word(5'd14, 16'hFFFC); instr_valid = 1; reg_a = 32'h0000_1000;
    st_ums_in = 1; st_vms_in = 0; irq_req = 1; st_ie_in = 1; brk_req = 1;
    #2;
    check("R1 ra_sel", {27'b0, ra_sel}, 14);
    check("R4 irq held on return", {31'b0, irq_take}, 0);
    check("R7 ack before accept", {30'b0, irq_ack}, 0);
    nxt();
    check("R7 ack 10", {30'b0, irq_ack}, 2);
    check("R3 no branch in slot", {31'b0, branch_valid}, 0);
    instr = ADD_WORD; reg_a = 32'hDEAD_0000; st_ums_in = 0; #2;
    check("R4 irq held in slot", {31'b0, irq_take}, 0);
    check("R4 brk held in slot", {31'b0, brk_take}, 0);
    check("R9 legal slot", {31'b0, illegal_slot}, 0);
    nxt();
    check("R2 branch pulse", {31'b0, branch_valid}, 1);
    check("R2 target", branch_target, 32'h0000_0FFC);
    check("R6 status", {28'b0, st_we, st_ie, st_um, st_vm}, 4'b1110);
    check("R4 brk held at branch", {31'b0, brk_take}, 0);
    instr_valid = 0; irq_req = 0; brk_req = 0; st_ie_in = 0;
    nxt();
    check("R7 ack 11", {30'b0, irq_ack}, 3);
    check("R2 single pulse", {31'b0, branch_valid}, 0);
    nxt();
    check("R7 ack back to 00", {30'b0, irq_ack}, 0);
  endtask

  task automatic t_stall();
    instr = ret_word(5'd3, 16'h0010); instr_valid = 1; reg_a = 32'hFFFF_FFF8;
    st_ums_in = 0; st_vms_in = 1;
    nxt();
    instr = ADD_WORD; stall = 1;
    nxt();
    check("R3 stalled slot", {31'b0, branch_valid}, 0);
    check("R8 ack held", {30'b0, irq_ack}, 2);
    stall = 0; instr_valid = 0;
    nxt();
    check("R3 bubble slot", {31'b0, branch_valid}, 0);
    instr_valid = 1;
    nxt();
    check("R2 wrap target", branch_target, 32'h0000_0008);
    check("R6 vm restore", {28'b0, st_we, st_ie, st_um, st_vm}, 4'b1101);
    instr_valid = 0; stall = 1;
    nxt();
    check("R8 ack held in stall", {30'b0, irq_ack}, 2);
    stall = 0;
    nxt();
    check("R8 ack 11 after stall", {30'b0, irq_ack}, 3);
    nxt();
    check("R7 ack 00", {30'b0, irq_ack}, 0);
  endtask

  task automatic t_priv();
    mem_prot_en = 1; st_um_in = 1;
    instr = ret_word(5'd14, 16'h0000); instr_valid = 1; reg_a = 32'h100;
    nxt();
    instr_valid = 0;
    check("R5 exception", {31'b0, exc_valid}, 1);
    check("R5 code", {27'b0, exc_code}, 5'b00111);
    check("R5 ack stays", {30'b0, irq_ack}, 0);
    nxt();
    check("R5 no branch", {30'b0, branch_valid, st_we}, 0);
    check("R5 single pulse", {31'b0, exc_valid}, 0);
  endtask

  task automatic t_noprot();
    mem_prot_en = 0; st_um_in = 1;
    instr = ret_word(5'd14, 16'h0004); instr_valid = 1; reg_a = 32'h200;
    nxt();
    check("R11 accepted in user mode", {30'b0, irq_ack}, 2);
    check("R11 no exception", {31'b0, exc_valid}, 0);
    instr = {6'b101100, 26'h0}; #2;
    check("R9 imm prefix in slot", {31'b0, illegal_slot}, 1);
    nxt();
    check("R11 branch", branch_target, 32'h0000_0204);
    instr_valid = 0; st_um_in = 0;
    repeat (2) nxt();
  endtask

  task automatic t_illegal_branch();
    instr = ret_word(5'd1, 16'h0000); instr_valid = 1; reg_a = 32'h40;
    nxt();
    instr = {6'b100110, 26'h0}; #2;
    check("R9 branch in slot", {31'b0, illegal_slot}, 1);
    nxt();
    instr_valid = 0; #2;
    check("R9 flag only in slot", {31'b0, illegal_slot}, 0);
    repeat (2) nxt();
  endtask

  task automatic t_idle();
    instr_valid = 1; instr = {6'b101101, 5'b10000, 5'd14, 16'h0}; irq_req = 1; st_ie_in = 1; brk_req = 1;
    #2;
    check("R4 irq taken when idle", {31'b0, irq_take}, 1);
    check("R4 brk taken when idle", {31'b0, brk_take}, 1);
    nxt();
    check("R1 other sub-code ignored", {30'b0, irq_ack}, 0);
    nxt();
    check("R1 no branch for other sub-code", {31'b0, branch_valid}, 0);
    instr_valid = 1; instr = {6'b101100, 26'h0}; #2;
    check("R9 no flag outside slot", {31'b0, illegal_slot}, 0);
    idle_inputs();
    nxt();
  endtask

  initial begin
    #(20000 * 20);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    idle_inputs(); nxt();
    t_stall();
    idle_inputs(); nxt();
    t_priv();
    idle_inputs(); nxt();
    t_noprot();
    idle_inputs(); nxt();
    t_illegal_branch();
    idle_inputs(); nxt();
    t_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule